// File: doc/BRIEF.md
# Dual-Rate Serial Result Output Port

This block puts the result of a 16-bit converter onto one serial data line and offers two ways to read it. While a conversion runs, each bit can be watched on the line as soon as the sequencer decides it, paced by the conversion clock. After the conversion, the stored word can be clocked out by a separate serial clock that has no fixed relation to the conversion clock. The conversion-busy signal from the sequencer frames the live stream and selects the source of the line.

The active-low select gates the output driver and starts each post-conversion read. Every completed word crosses from the conversion-clock domain into the serial-clock domain through a toggle request and acknowledge pair. The crossing word is held still for as long as the request is outstanding. The serial clock is taken to run continuously. The select input is taken to be synchronous to it, and bits advance only while the select is low.

Top module: `serial_result_port`

## Requirements
- R1: While `csN` is high, `dataOutEn` is 0 and `dataOut` is 0, whatever the rest of the block is doing.
- R2: After reset, the stored result is all zeros. A read started before any word completes returns zeros on every bit.
- R3: While `convBusy` is 1 and `csN` is 0, `dataOut` shows the bit given with the most recent `bitValid` pulse, starting on the conversion-clock edge that samples that pulse. It holds that bit until the next pulse.
- R4: The serial-clock edge that first samples `csN` low loads the latest completed word into the shifter. From that edge on, `dataOut` shows the word's most significant bit (bit 15).
- R5: Each later serial-clock edge with `csN` still low presents the next lower bit, so the word leaves most significant bit first.
- R6: Once all 16 bits have been presented, `dataOut` stays 0 on every further edge until `csN` goes high.
- R7: A word given with a `doneValid` pulse reaches the serial-clock domain through a toggle request/acknowledge handshake. It is available to a read that starts 20 conversion-clock cycles after the pulse.
- R8: A word that completes while a read is in progress does not change the bits of that read. The next fall of `csN` loads the new word.
- R9: When several words complete while the handshake is busy, the most recent one is the word that reaches the serial domain.
- R10: Raising `csN` in the middle of a read and lowering it again starts a fresh read from bit 15 of the latest word.
- R11: While `convBusy` is 0, `bitValid` pulses have no effect on `dataOut`. The line carries the post-conversion shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| convClk | input | 1 | Conversion clock |
| convRstN | input | 1 | Active-low reset, conversion-clock domain |
| serClk | input | 1 | Serial read clock, unrelated to convClk |
| serRstN | input | 1 | Active-low reset, serial-clock domain |
| csN | input | 1 | Active-low select, synchronous to serClk |
| convBusy | input | 1 | High while a conversion runs; frames the live stream |
| bitValid | input | 1 | One-cycle strobe: a bit has just been decided |
| bitValue | input | 1 | Value of the decided bit |
| doneValid | input | 1 | One-cycle strobe: a conversion has finished |
| doneWord | input | 16 | Finished result word |
| dataOut | output | 1 | Serial data, most significant bit first |
| dataOutEn | output | 1 | Driver enable for the tri-state pad, high while selected |

## Verification
A wrong bit counter or a missed shift enable shows on the line within one serial-clock edge of the read start. The bit stream is either misplaced against the expected most-significant-first sequence, or it fails to settle to zeros after sixteen edges. A broken crossing does not show until the next read. That read returns the previous word, or a torn mix of two words, so each word is read out completely after it completes. Back-to-back completions and a completion in the middle of a read are forced on purpose, because these are the only patterns that expose a handshake that drops the newest word or overwrites the word being shifted.

// File: rtl/sro_pkg.sv
package sro_pkg;
  typedef struct packed {
    logic captureWord;
    logic loadShift;
    logic shiftStep;
  } serStrobes_t;
endpackage

// File: rtl/sro_sync.sv
module sro_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sro_conv_ctrl.sv
module sro_conv_ctrl #(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              convClk,
  input  logic              convRstN,
  input  logic              convBusy,
  input  logic              bitValid,
  input  logic              bitValue,
  input  logic              doneValid,
  input  logic [WORD_W-1:0] doneWord,
  input  logic              ackTgl,
  output logic              liveBit,
  output logic              reqTgl,
  output logic [WORD_W-1:0] holdWord
);
  logic              ackSync;
  logic              fresh;
  logic [WORD_W-1:0] freshWord;
  logic              idle;

  sro_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(convClk), .rstN(convRstN), .d(ackTgl), .q(ackSync)
  );

  assign idle = (reqTgl == ackSync);

  // live stream: latest decided bit, cleared outside a conversion
  always_ff @(posedge convClk or negedge convRstN) begin
    if (!convRstN)     liveBit <= 1'b0;
    else if (!convBusy) liveBit <= 1'b0;
    else if (bitValid)  liveBit <= bitValue;
  end

  // newest finished word waits here until the handshake is idle
  always_ff @(posedge convClk or negedge convRstN) begin
    if (!convRstN) begin
      freshWord <= '0;
      fresh     <= 1'b0;
      holdWord  <= '0;
      reqTgl    <= 1'b0;
    end else begin
      if (doneValid) freshWord <= doneWord;
      if (idle && fresh) begin
        holdWord <= freshWord;
        reqTgl   <= ~reqTgl;
      end
      if (doneValid)          fresh <= 1'b1;
      else if (idle && fresh) fresh <= 1'b0;
    end
  end

  a_r7_hold_stable: assert property (@(posedge convClk) disable iff (!convRstN)
    (reqTgl != ackSync) |=> $stable(holdWord));

  a_r7_launch_idle: assert property (@(posedge convClk) disable iff (!convRstN)
    (reqTgl != $past(reqTgl)) |-> ($past(reqTgl) == $past(ackSync)));
endmodule

// File: rtl/sro_ser_ctrl.sv
module sro_ser_ctrl
  import sro_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        serClk,
  input  logic        serRstN,
  input  logic        csN,
  input  logic        reqTgl,
  output logic        ackTgl,
  output serStrobes_t strobes
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

  logic             reqSync;
  logic             csPrevN;
  logic [CNT_W-1:0] bitCnt;

  sro_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(serClk), .rstN(serRstN), .d(reqTgl), .q(reqSync)
  );

  always_comb begin
    strobes.captureWord = (reqSync != ackTgl);
    strobes.loadShift   = csPrevN && !csN;
    strobes.shiftStep   = !csPrevN && !csN && (bitCnt < LAST);
  end

  always_ff @(posedge serClk or negedge serRstN) begin
    if (!serRstN) begin
      ackTgl  <= 1'b0;
      csPrevN <= 1'b1;
      bitCnt  <= '0;
    end else begin
      csPrevN <= csN;
      if (strobes.captureWord) ackTgl <= reqSync;
      if (strobes.loadShift)      bitCnt <= '0;
      else if (strobes.shiftStep) bitCnt <= bitCnt + 1'b1;
    end
  end

  a_r6_cnt_bound: assert property (@(posedge serClk) disable iff (!serRstN)
    bitCnt <= LAST);

  a_r4_load_restarts: assert property (@(posedge serClk) disable iff (!serRstN)
    strobes.loadShift |=> (bitCnt == '0));
endmodule

// File: rtl/sro_ser_dp.sv
module sro_ser_dp
  import sro_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              serClk,
  input  logic              serRstN,
  input  serStrobes_t       strobes,
  input  logic [WORD_W-1:0] holdWord,
  output logic              shiftMsb
);
  logic [WORD_W-1:0] latestWord;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge serClk or negedge serRstN) begin
    if (!serRstN) begin
      latestWord <= '0;
      shiftReg   <= '0;
    end else begin
      if (strobes.captureWord) latestWord <= holdWord;
      if (strobes.loadShift)      shiftReg <= latestWord;
      else if (strobes.shiftStep) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign shiftMsb = shiftReg[WORD_W-1];

  a_r4_load_msb: assert property (@(posedge serClk) disable iff (!serRstN)
    strobes.loadShift |=> (shiftMsb == $past(latestWord[WORD_W-1])));

  a_r8_shift_untouched: assert property (@(posedge serClk) disable iff (!serRstN)
    !(strobes.loadShift || strobes.shiftStep) |=> $stable(shiftReg));
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import sro_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              convClk,
  input  logic              convRstN,
  input  logic              serClk,
  input  logic              serRstN,
  input  logic              csN,
  input  logic              convBusy,
  input  logic              bitValid,
  input  logic              bitValue,
  input  logic              doneValid,
  input  logic [WORD_W-1:0] doneWord,
  output logic              dataOut,
  output logic              dataOutEn
);
  logic              liveBit;
  logic              reqTgl;
  logic              ackTgl;
  logic [WORD_W-1:0] holdWord;
  logic              shiftMsb;
  serStrobes_t       strobes;

  sro_conv_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_convCtrl (
    .convClk(convClk), .convRstN(convRstN), .convBusy(convBusy),
    .bitValid(bitValid), .bitValue(bitValue), .doneValid(doneValid),
    .doneWord(doneWord), .ackTgl(ackTgl), .liveBit(liveBit),
    .reqTgl(reqTgl), .holdWord(holdWord)
  );

  sro_ser_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_serCtrl (
    .serClk(serClk), .serRstN(serRstN), .csN(csN), .reqTgl(reqTgl),
    .ackTgl(ackTgl), .strobes(strobes)
  );

  sro_ser_dp #(.WORD_W(WORD_W)) u_serDp (
    .serClk(serClk), .serRstN(serRstN), .strobes(strobes),
    .holdWord(holdWord), .shiftMsb(shiftMsb)
  );

  assign dataOutEn = !csN;
  assign dataOut   = csN ? 1'b0 : (convBusy ? liveBit : shiftMsb);
endmodule

// File: tb/serial_result_port_bench.sv
module serial_result_port_bench;
  logic convClk = 0, serClk = 0;
  logic convRstN = 0, serRstN = 0;
  logic csN = 1, convBusy = 0, bitValid = 0, bitValue = 0, doneValid = 0;
  logic [15:0] doneWord = '0;
  logic dataOut, dataOutEn;
  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [15:0] VEC [6] = '{16'hA5C3, 16'hFFFF, 16'h0000,
                                      16'h0001, 16'h8000, 16'h1234};

  always #2 serClk = ~serClk;
  always #3.5 convClk = ~convClk;

  serial_result_port u_serial_result_port (
    .convClk(convClk), .convRstN(convRstN), .serClk(serClk), .serRstN(serRstN),
    .csN(csN), .convBusy(convBusy), .bitValid(bitValid), .bitValue(bitValue),
    .doneValid(doneValid), .doneWord(doneWord), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R4 R5 R6: read nbits, check MSB first then zeros
  task automatic readCheck(logic [15:0] w, int nbits, string tag);
    @(negedge serClk) csN = 0;
    @(negedge serClk);
    check({tag, " R4 msb"}, {15'd0, dataOut}, {15'd0, w[15]});
    check({tag, " R1 enable"}, {15'd0, dataOutEn}, 16'd1);
    for (int i = 1; i < nbits; i++) begin
      @(negedge serClk);
      if (i < 16) check({tag, " R5 bit"}, {15'd0, dataOut}, {15'd0, w[15-i]});
      else        check({tag, " R6 tail"}, {15'd0, dataOut}, 16'd0);
    end
    @(negedge serClk) csN = 1;
    #1 check({tag, " R1 idle"}, {14'd0, dataOutEn, dataOut}, 16'd0);
  endtask

  // R7: pulse a finished word and leave time for the crossing
  task automatic pulseDone(logic [15:0] w, int settle);
    @(negedge convClk) begin doneValid = 1; doneWord = w; end
    @(negedge convClk) doneValid = 0;
    repeat (settle) @(negedge convClk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge serClk);
    #1 check("R1 reset idle", {14'd0, dataOutEn, dataOut}, 16'd0);
    convRstN = 1; serRstN = 1;
    repeat (4) @(negedge serClk);
    readCheck(16'h0000, 17, "R2 after reset");

    // vector table walk: each finished word read out completely
    foreach (VEC[k]) begin
      pulseDone(VEC[k], 20);
      readCheck(VEC[k], 18, "R7 table");
    end

    // R11: bit strobes outside a conversion leave the line alone (latest MSB is 0)
    @(negedge convClk) begin bitValid = 1; bitValue = 1; end
    repeat (2) @(negedge convClk);
    bitValid = 0;
    readCheck(16'h1234, 2, "R11 idle strobes");

    // R10: abort mid-read, restart from MSB
    pulseDone(16'hC0DE, 20);
    readCheck(16'hC0DE, 5, "R10 partial");
    readCheck(16'hC0DE, 16, "R10 restart");

    // R9: back-to-back completions, newest wins
    @(negedge convClk) begin doneValid = 1; doneWord = 16'h1111; end
    @(negedge convClk) doneWord = 16'h7E57;
    @(negedge convClk) doneValid = 0;
    repeat (20) @(negedge convClk);
    readCheck(16'h7E57, 16, "R9 newest");

    // R8: completion during a read does not disturb it
    fork
      readCheck(16'h7E57, 18, "R8 ongoing");
      begin repeat (3) @(negedge convClk); pulseDone(16'h4BAD, 2); end
    join
    repeat (10) @(negedge convClk);
    readCheck(16'h4BAD, 16, "R8 next read");

    // R3: live stream during a conversion; R1 while deselected
    @(negedge convClk) convBusy = 1;
    @(negedge convClk) begin bitValid = 1; bitValue = 1; end
    @(negedge convClk) begin bitValid = 0; #1 check("R1 busy deselected", {14'd0, dataOutEn, dataOut}, 16'd0); end
    csN = 0;
    begin
      logic [15:0] pat = 16'hB3A1;
      for (int i = 15; i >= 0; i--) begin
        @(negedge convClk) begin bitValid = 1; bitValue = pat[i]; end
        @(negedge convClk) bitValid = 0;
        check("R3 live bit", {15'd0, dataOut}, {15'd0, pat[i]});
      end
      @(negedge convClk);
      check("R3 live hold", {15'd0, dataOut}, {15'd0, pat[0]});
    end
    convBusy = 0; csN = 1;
    #1 check("R1 after live", {14'd0, dataOutEn, dataOut}, 16'd0);
    repeat (4) @(negedge serClk);
    finish_run();
  end
endmodule